// File: doc/BRIEF.md
# Serial Boot Identification Responder

This block listens to the byte stream coming out of a UART receiver and picks out a short identification query. The query opens with a `>` character used only for timing, then a space, then the keyword `ID_CHK`. Four hexadecimal numbers follow, in this order: a mask for pin group A, the expected value for group A, a mask for group B, and the expected value for group B. When the last number is closed by a whitespace character, the block compares its two 32-bit pin inputs against the masks and data. If both groups match, it waits for a turnaround interval and then sends a fixed identity line to the UART transmitter through a valid/ready handshake.

Several devices can share one serial line. Each device sees the same query, and only the devices whose strap pins satisfy the masked comparison answer. A query made of all-zero fields selects every device. If the line goes quiet in the middle of a query for longer than the inactivity limit, the parser drops the partial query and waits for a new `>`. Bytes that arrive while a reply is being prepared or sent are discarded, because the link is half duplex. Baud detection, UART framing and image loading belong to other blocks.

Top module: `boot_id_responder`

## Requirements
- R1: After reset, `tx_valid` is low and the parser waits for a `>` byte.
- R2: A complete matching query produces exactly the 12 bytes 0x0D, 0x0A, "ID_VER ", the version letter (default "G"), 0x0D, 0x0A, in that order, and nothing else.
- R3: The reply is sent only when (pins_a & maskA) == dataA and (pins_b & maskB) == dataB, using the pin values present when the final field ends. All-zero fields always match, and a mismatch in either group produces no reply.
- R4: Hex digits 0-9, A-F and a-f are all accepted. A field with more than 8 digits keeps its last 8 digits, so the value is truncated to 32 bits.
- R5: A field ends on a whitespace byte (0x20, 0x0D, 0x0A or 0x09) that follows at least one digit. Whitespace before a field's first digit is skipped. Without a terminator after the fourth field, no reply is sent.
- R6: If `>` is not followed by a space, if a keyword byte is wrong, or if a non-hex, non-whitespace byte appears in a field, the query is dropped and the parser waits for a new `>`.
- R7: If more than TIMEOUT_CYC clock cycles pass between two received bytes while a query is partly parsed, the parse restarts. Gaps shorter than this limit are tolerated.
- R8: `tx_valid` stays low for at least TURN_CYC cycles after the byte that ends the query.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R10: Bytes received while a reply is pending or being sent are ignored. After a reply ends, each new query gets its own reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte offered to the transmitter |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| pins_a | input | 32 | Live state of pin group A |
| pins_b | input | 32 | Live state of pin group B |

## Verification
The hardest situation to reach is a query that overlaps a reply still in progress. It only arises when a second query is streamed in while the turnaround wait and the transmitter stalls are both holding the reply open. The bench brings this about by sending a second full query straight after a terminator, while `tx_ready` drops one cycle in three. This shows that the overlapping bytes produce no second reply. Timeout cases use gaps set well on either side of the limit, and a query left without its final terminator is completed with a carriage return before the limit expires.

// File: rtl/boot_id_pkg.sv
package boot_id_pkg;

  localparam int KEY_LEN   = 6;
  localparam int REPLY_LEN = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_KEY, S_FIELD, S_WAIT, S_SEND
  } parse_state_t;

  // keyword "ID_CHK"
  function automatic logic [7:0] key_char(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h49;
      3'd1:    return 8'h44;
      3'd2:    return 8'h5F;
      3'd3:    return 8'h43;
      3'd4:    return 8'h48;
      default: return 8'h4B;
    endcase
  endfunction

  // CR LF "ID_VER " <ver> CR LF
  function automatic logic [7:0] reply_char(input logic [3:0] i, input logic [7:0] ver);
    case (i)
      4'd0:    return 8'h0D;
      4'd1:    return 8'h0A;
      4'd2:    return 8'h49;
      4'd3:    return 8'h44;
      4'd4:    return 8'h5F;
      4'd5:    return 8'h56;
      4'd6:    return 8'h45;
      4'd7:    return 8'h52;
      4'd8:    return 8'h20;
      4'd9:    return ver;
      4'd10:   return 8'h0D;
      default: return 8'h0A;
    endcase
  endfunction

  function automatic logic is_blank(input logic [7:0] c);
    return (c == 8'h20) || (c == 8'h0D) || (c == 8'h0A) || (c == 8'h09);
  endfunction

  // {valid, nibble}
  function automatic logic [4:0] hex_nib(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39)                                   return {1'b1, c[3:0]};
    else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) return {1'b1, c[3:0] + 4'd9};
    else                                                            return 5'd0;
  endfunction

endpackage

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic kick,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active || kick) cnt <= '0;
    else if (cnt != LIM)        cnt <= cnt + 1'b1;
  end

  assign expired = active && (cnt == LIM);

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kick |=> !expired); // R7
endmodule

// File: rtl/reply_tx.sv
module reply_tx
  import boot_id_pkg::*;
#(
  parameter logic [7:0] VER = 8'h47
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       done
);
  localparam logic [3:0] LAST = 4'(REPLY_LEN - 1);

  logic [3:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
      idx      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tx_valid <= 1'b1;
        tx_data  <= reply_char(4'd0, VER);
        idx      <= '0;
      end else if (tx_valid && tx_ready) begin
        if (idx == LAST) begin
          tx_valid <= 1'b0;
          done     <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          tx_data <= reply_char(idx + 1'b1, VER);
        end
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9
endmodule

// File: rtl/boot_id_responder.sv
module boot_id_responder
  import boot_id_pkg::*;
#(
  parameter int         TIMEOUT_CYC = 10_000_000,
  parameter int         TURN_CYC    = 100_000,
  parameter logic [7:0] VER_LETTER  = 8'h47
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic [31:0] pins_a,
  input  logic [31:0] pins_b
);
  localparam int TW = $clog2(TURN_CYC + 1);
  localparam logic [TW-1:0] TURN_END = TW'(TURN_CYC - 1);
  localparam logic [2:0]    KEY_END  = 3'(KEY_LEN - 1);

  parse_state_t state;
  logic [2:0]   key_idx;
  logic [1:0]   fld_idx;
  logic         have_digit;
  logic [31:0]  acc;
  logic [31:0]  fld_q [0:2];
  logic [TW-1:0] turn_cnt;
  logic         start;
  logic         done;
  logic         expired;
  logic         parsing;
  logic [4:0]   nib;
  logic         fields_ok;

  assign parsing   = (state == S_GAP) || (state == S_KEY) || (state == S_FIELD);
  assign nib       = hex_nib(rx_data);
  assign fields_ok = ((pins_a & fld_q[0]) == fld_q[1]) && ((pins_b & fld_q[2]) == acc);

  idle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .active(parsing), .kick(rx_valid), .expired(expired)
  );

  reply_tx #(.VER(VER_LETTER)) u_tx (
    .clk(clk), .rst(rst), .start(start), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      key_idx    <= '0;
      fld_idx    <= '0;
      have_digit <= 1'b0;
      acc        <= '0;
      turn_cnt   <= '0;
      start      <= 1'b0;
      for (int i = 0; i < 3; i++) fld_q[i] <= '0;
    end else begin
      start <= 1'b0;
      if (expired) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (rx_valid && rx_data == 8'h3E) state <= S_GAP;
          S_GAP: if (rx_valid) begin
            key_idx <= '0;
            state   <= (rx_data == 8'h20) ? S_KEY : S_IDLE;
          end
          S_KEY: if (rx_valid) begin
            if (rx_data != key_char(key_idx)) begin
              state <= S_IDLE;
            end else if (key_idx == KEY_END) begin
              state      <= S_FIELD;
              fld_idx    <= '0;
              acc        <= '0;
              have_digit <= 1'b0;
            end else begin
              key_idx <= key_idx + 1'b1;
            end
          end
          S_FIELD: if (rx_valid) begin
            if (nib[4]) begin
              acc        <= {acc[27:0], nib[3:0]};
              have_digit <= 1'b1;
            end else if (is_blank(rx_data)) begin
              if (have_digit) begin
                if (fld_idx == 2'd3) begin
                  turn_cnt <= '0;
                  state    <= fields_ok ? S_WAIT : S_IDLE;
                end else begin
                  fld_q[fld_idx] <= acc;
                  fld_idx        <= fld_idx + 1'b1;
                end
                acc        <= '0;
                have_digit <= 1'b0;
              end
            end else begin
              state <= S_IDLE;
            end
          end
          S_WAIT: begin
            if (turn_cnt == TURN_END) begin
              start <= 1'b1;
              state <= S_SEND;
            end else begin
              turn_cnt <= turn_cnt + 1'b1;
            end
          end
          S_SEND: if (done) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    expired |=> (state == S_IDLE)); // R7
  AST_TX_ONLY_SEND: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (state == S_SEND)); // R10
  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> !tx_valid); // R8
  AST_WAIT_FROM_FIELD: assert property (@(posedge clk) disable iff (rst)
    ((state == S_WAIT) && !$past(rst)) |-> ($past(state) == S_WAIT || $past(state) == S_FIELD)); // R5
  AST_SEND_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == S_SEND && done) |=> (state == S_IDLE)); // R10
endmodule

// File: tb/boot_id_responder_bench.sv
module boot_id_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TOUT = 40;
  localparam int TURN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic [31:0] pins_a = '0;
  logic [31:0] pins_b = '0;
  logic [1:0]  rdy_cnt = '0;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expq [$];
  bit   ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) rdy_cnt <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
  assign tx_ready = (rdy_cnt != 2'd2);

  boot_id_responder #(.TIMEOUT_CYC(TOUT), .TURN_CYC(TURN)) u_boot_id_responder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .pins_a(pins_a), .pins_b(pins_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare and hold check
  bit         prev_stall = 0;
  logic [7:0] prev_data  = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(tx_valid && tx_data == prev_data, "R9 hold", {tx_valid, tx_data}, {1'b1, prev_data});
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) check(0, "R2/R3 unexpected byte", tx_data, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(tx_data == e, "R2 reply byte", tx_data, e);
        end
      end
    end
  end

  task automatic push_reply();
    string r;
    r = "\r\nID_VER G\r\n";
    for (int i = 0; i < r.len(); i++) expq.push_back(r[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i], (i == s.len() - 1) ? 0 : 1);
  endtask

  task automatic drained(input string req);
    repeat (80) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
    expq.delete();
  endtask

  task automatic query(input string s, input bit hit, input string req);
    if (hit) push_reply();
    send_str(s);
    drained(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0, "R1 reset tx_valid", tx_valid, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b0, "R1 idle after reset", tx_valid, 0);

    // R2 R3 all-zero query selects, with R8 turnaround quiet check
    push_reply();
    send_str("> ID_CHK 0 0 0 0 ");
    for (int i = 0; i < TURN - 1; i++) begin
      check(!tx_valid, "R8 turnaround", tx_valid, 0);
      @(negedge clk);
    end
    drained("R2 all-zero reply complete");

    // R3 R4 masked match, mixed case
    pins_a = 32'h1234_5678;
    pins_b = 32'hABCD_0005;
    query("> ID_CHK FFff0000 12340000 0f 5\r", 1, "R4 mixed case match");
    query("> ID_CHK ffff0000 12350000 0 0 ", 0, "R3 group A mismatch");
    query("> ID_CHK 0 0 F 4 ", 0, "R3 group B mismatch");
    // R4 truncation: 10 digits keep last 8
    query("> ID_CHK 770000000F 8 0 0 ", 1, "R4 truncated mask");
    query("> ID_CHK 0 0 0\t  0", 0, "R5 no terminator");
    // R5 late terminator completes query within timeout
    push_reply();
    send_str("> ID_CHK 0 0 0 0");
    repeat (20) @(negedge clk);
    check(expq.size() == 12, "R5 held until terminator", expq.size(), 12);
    send_byte(8'h0D, 0);
    drained("R5 CR terminator");

    // R6 malformed
    query(">ID_CHK 0 0 0 0 ", 0, "R6 missing space");
    query("> ID_CHX 0 0 0 0 ", 0, "R6 keyword mismatch");
    query("> ID_CHK 0 0 0 g ", 0, "R6 bad field char");

    // R7 timeout
    push_reply();
    send_str("> ID_CHK 0 0 ");
    repeat (30) @(negedge clk);
    send_str("0 0 ");
    drained("R7 short gap tolerated");
    send_str("> ID_CHK 0 0 ");
    repeat (60) @(negedge clk);
    send_str("0 0 ");
    drained("R7 long gap restarts");

    // R10 overlap ignored, then repeated queries
    push_reply();
    send_str("> ID_CHK 0 0 0 0 ");
    send_str("> ID_CHK 0 0 0 0 ");
    drained("R10 overlap ignored");
    for (int k = 0; k < 3; k++) begin
      push_reply();
      send_str("> ID_CHK 0 0 0 0 ");
      repeat (60) @(negedge clk);
    end
    drained("R10 repeated queries");

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      check(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule